// File: doc/BRIEF.md
# Parallel Port Receive FIFO DMA Request Controller

This block drives the DMA request line for a 16-byte, 8-bit receive FIFO that drains toward the host when an extended-capability parallel port runs in the reverse direction. The FIFO itself is outside the block. The block sees only the FIFO's occupancy count. It also watches the host side of the transfer: the active-low DMA acknowledge, the active-low I/O read strobe and the terminal-count signal. From these it decides cycle by cycle whether to request another transfer.

The block holds two software control bits. One is a DMA enable. The other is a service flag, which blocks requests while it is set. Software writes both bits together through a single write strobe. The request is raised while DMA is enabled, the service flag is clear and the FIFO holds data.

The request drops in two ways, and they recover differently:
- **FIFO empty.** The request drops when the FIFO runs empty and returns by itself when data arrives again.
- **Terminal count.** Terminal count is qualified by an active acknowledge. It is taken on the acknowledge's falling edge, or on the read strobe's falling edge when the acknowledge was already low. Hardware then sets the service flag, so the request stays off until software clears that flag again.

Top module: `pp_dma_req`

## Requirements
- R1: While `rst` is high and on the first edge after it, `dma_req` is 0 and `svc_flag` is 1. DMA enable resets to 0, so with data in the FIFO and no control write, `dma_req` stays 0.
- R2: `dma_req` is 1 after the edge at which enable is 1, the service flag is 0 and `fifo_count` is at least 1. The enable and flag values used are those taken at that same edge. Writing enable=1 and flag=0 while `fifo_count` is 0 leaves `dma_req` at 0.
- R3: If `fifo_count` is 0 at an edge, `dma_req` is 0 after that edge.
- R4: After a drop caused by an empty FIFO, `dma_req` returns to 1 one edge after `fifo_count` is nonzero again. No control write is needed.
- R5: Terminal count is taken on the acknowledge edge. This happens when `term_cnt` is 1, `dma_ack_n` is 0 and `dma_ack_n` was 1 at the previous edge. After that edge, `dma_req` is 0 and `svc_flag` is 1.
- R6: Terminal count can also be taken on the read strobe with no acknowledge edge. This happens when `term_cnt` is 1, `dma_ack_n` was already 0 at the previous edge and is still 0, and `io_rd_n` falls from 1 to 0. After that edge, `dma_req` is 0 and `svc_flag` is 1. With `dma_ack_n` held low and no strobe edge, `term_cnt` has no effect.
- R7: `term_cnt` while `dma_ack_n` is 1 has no effect on `dma_req` or `svc_flag`.
- R8: After a terminal count, `dma_req` stays 0 whatever the FIFO count, including after a write of enable=1 and flag=1. A write of flag=0 with enable=1 brings `dma_req` back one edge later if the FIFO holds data.
- R9: A write (`ctl_wr`=1) loads `ctl_dma_en` and `ctl_svc` at the next edge. Writing enable=0 drops `dma_req` after that edge.
- R10: When a write and a terminal count fall on the same edge, the service flag ends at 1 and the enable takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_count | input | 5 | Bytes held in the receive FIFO (0 to 16) |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| term_cnt | input | 1 | Terminal count from the DMA controller |
| ctl_wr | input | 1 | Write strobe for the two control bits |
| ctl_dma_en | input | 1 | Value written to the DMA enable |
| ctl_svc | input | 1 | Value written to the service flag |
| dma_req | output | 1 | DMA request, registered |
| svc_flag | output | 1 | Service flag, set by terminal count, registered |

## Verification
The hardest case to reach is a terminal count taken on the read strobe rather than on the acknowledge. To get there, the acknowledge must already be low at the previous edge, so no fresh acknowledge edge exists. The stimulus table first lowers the acknowledge on one row without terminal count. On the next row it keeps the acknowledge low, drops the read strobe and raises terminal count together. A further row holds the acknowledge low with terminal count high and no strobe edge at all, which shows that the level alone does not end the transfer. Same-edge collisions are also covered: a control write against a terminal count, and a write arriving with an empty FIFO.

// File: rtl/pp_dma_req_pkg.sv
package pp_dma_req_pkg;
  typedef struct packed {
    logic dma_en;
    logic svc;
  } ctl_t;

  localparam int STROBE_ACK = 0;
  localparam int STROBE_RD  = 1;
  localparam int NUM_STROBE = 2;
endpackage

// File: rtl/pp_dma_req_edge.sv
module pp_dma_req_edge #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] strobe_n,
  output logic [NUM-1:0] fall
);
  logic [NUM-1:0] prev_q;

  generate
    for (genvar g = 0; g < NUM; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) prev_q[g] <= 1'b1;
        else     prev_q[g] <= strobe_n[g];
      end
      assign fall[g] = prev_q[g] & ~strobe_n[g];
    end
  endgenerate

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall[0] |-> $past(strobe_n[0])); // R5
endmodule

// File: rtl/pp_dma_req_ctl.sv
module pp_dma_req_ctl
  import pp_dma_req_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wr_dma_en,
  input  logic wr_svc,
  input  logic term_cnt,
  input  logic ack_n,
  input  logic [NUM_STROBE-1:0] fall,
  output logic tc_hit,
  output ctl_t state_d,
  output ctl_t state_q
);
  // A terminal count counts only while the acknowledge is active, and only on
  // a fresh acknowledge edge or, failing that, a read strobe edge.
  assign tc_hit = term_cnt & ~ack_n & (fall[STROBE_ACK] | fall[STROBE_RD]);

  always_comb begin
    state_d = state_q;
    if (wr) begin
      state_d.dma_en = wr_dma_en;
      state_d.svc    = wr_svc;
    end
    if (tc_hit) state_d.svc = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q.dma_en <= 1'b0;
      state_q.svc    <= 1'b1;
    end else begin
      state_q <= state_d;
    end
  end

  AST_TC_SETS_SVC: assert property (@(posedge clk) disable iff (rst)
    tc_hit |=> state_q.svc); // R5
  AST_SVC_CLEAR_BY_SW: assert property (@(posedge clk) disable iff (rst)
    $fell(state_q.svc) |-> $past(wr)); // R8
  AST_EN_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    !$stable(state_q.dma_en) |-> $past(wr)); // R9
  AST_TC_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
    tc_hit |-> !ack_n); // R7
endmodule

// File: rtl/pp_dma_req_gen.sv
module pp_dma_req_gen
  import pp_dma_req_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  ctl_t             state_d,
  input  logic             tc_hit,
  output logic             dma_req
);
  logic req_d;

  assign req_d = state_d.dma_en & ~state_d.svc & (fifo_count != '0);

  always_ff @(posedge clk) begin
    if (rst) dma_req <= 1'b0;
    else     dma_req <= req_d;
  end

  AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0) |=> !dma_req); // R3
  AST_TC_DROPS: assert property (@(posedge clk) disable iff (rst)
    tc_hit |=> !dma_req); // R5
endmodule

// File: rtl/pp_dma_req.sv
module pp_dma_req
  import pp_dma_req_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  input  logic                            dma_ack_n,
  input  logic                            io_rd_n,
  input  logic                            term_cnt,
  input  logic                            ctl_wr,
  input  logic                            ctl_dma_en,
  input  logic                            ctl_svc,
  output logic                            dma_req,
  output logic                            svc_flag
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [NUM_STROBE-1:0] strobe_n;
  logic [NUM_STROBE-1:0] fall;
  logic                  tc_hit;
  ctl_t                  state_d;
  ctl_t                  state_q;

  assign strobe_n[STROBE_ACK] = dma_ack_n;
  assign strobe_n[STROBE_RD]  = io_rd_n;

  pp_dma_req_edge #(.NUM(NUM_STROBE)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (strobe_n),
    .fall     (fall)
  );

  pp_dma_req_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .wr_dma_en (ctl_dma_en),
    .wr_svc    (ctl_svc),
    .term_cnt  (term_cnt),
    .ack_n     (dma_ack_n),
    .fall      (fall),
    .tc_hit    (tc_hit),
    .state_d   (state_d),
    .state_q   (state_q)
  );

  pp_dma_req_gen #(.CNT_W(CNT_W)) u_gen (
    .clk        (clk),
    .rst        (rst),
    .fifo_count (fifo_count),
    .state_d    (state_d),
    .tc_hit     (tc_hit),
    .dma_req    (dma_req)
  );

  assign svc_flag = state_q.svc;

  AST_REQ_BLOCKED_BY_SVC: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> !svc_flag); // R8
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(FIFO_DEPTH)); // R2
endmodule

// File: tb/pp_dma_req_bench.sv
module pp_dma_req_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 5;
  localparam int NV = 25;

  typedef struct packed {
    logic          wr;
    logic          en;
    logic          svc;
    logic [CW-1:0] cnt;
    logic          ack_n;
    logic          rd_n;
    logic          tc;
    logic          ereq;
    logic          esvc;
    logic [3:0]    rq;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,5'd3, 1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd1},  // R1 no enable yet
    '{1'b1,1'b1,1'b0,5'd3, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd2},  // R2 arm
    '{1'b0,1'b0,1'b0,5'd3, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd2},
    '{1'b0,1'b0,1'b0,5'd0, 1'b1,1'b1,1'b0, 1'b0,1'b0, 4'd3},  // R3 empty
    '{1'b0,1'b0,1'b0,5'd1, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd4},  // R4 refill
    '{1'b0,1'b0,1'b0,5'd2, 1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd5},  // ack, no tc
    '{1'b0,1'b0,1'b0,5'd2, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd5},
    '{1'b0,1'b0,1'b0,5'd2, 1'b1,1'b1,1'b1, 1'b1,1'b0, 4'd7},  // R7 tc, ack idle
    '{1'b0,1'b0,1'b0,5'd1, 1'b0,1'b1,1'b1, 1'b0,1'b1, 4'd5},  // R5 tc on ack edge
    '{1'b0,1'b0,1'b0,5'd5, 1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd8},  // R8 stays off
    '{1'b1,1'b1,1'b1,5'd5, 1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd8},  // R8 enable only
    '{1'b1,1'b1,1'b0,5'd5, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd8},  // R8 re-arm
    '{1'b0,1'b0,1'b0,5'd5, 1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd6},  // ack falls
    '{1'b0,1'b0,1'b0,5'd4, 1'b0,1'b0,1'b1, 1'b0,1'b1, 4'd6},  // R6 tc on read edge
    '{1'b0,1'b0,1'b0,5'd4, 1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd8},
    '{1'b1,1'b1,1'b0,5'd4, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd8},
    '{1'b1,1'b0,1'b0,5'd4, 1'b1,1'b1,1'b0, 1'b0,1'b0, 4'd9},  // R9 disable
    '{1'b1,1'b1,1'b0,5'd0, 1'b1,1'b1,1'b0, 1'b0,1'b0, 4'd2},  // R2 no data
    '{1'b0,1'b0,1'b0,5'd16,1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd2},  // full FIFO
    '{1'b1,1'b1,1'b0,5'd16,1'b0,1'b1,1'b1, 1'b0,1'b1, 4'd10}, // R10 collision
    '{1'b0,1'b0,1'b0,5'd16,1'b1,1'b1,1'b0, 1'b0,1'b1, 4'd10}, // enable kept, svc held
    '{1'b1,1'b1,1'b0,5'd8, 1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd8},
    '{1'b0,1'b0,1'b0,5'd8, 1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd6},
    '{1'b0,1'b0,1'b0,5'd8, 1'b0,1'b1,1'b1, 1'b1,1'b0, 4'd6},  // R6 level alone
    '{1'b0,1'b0,1'b0,5'd8, 1'b0,1'b0,1'b1, 1'b0,1'b1, 4'd6}   // R6 strobe edge
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [CW-1:0] fifo_count;
  logic          dma_ack_n, io_rd_n, term_cnt;
  logic          ctl_wr, ctl_dma_en, ctl_svc;
  logic          dma_req, svc_flag;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_dma_req u_pp_dma_req (
    .clk        (clk),
    .rst        (rst),
    .fifo_count (fifo_count),
    .dma_ack_n  (dma_ack_n),
    .io_rd_n    (io_rd_n),
    .term_cnt   (term_cnt),
    .ctl_wr     (ctl_wr),
    .ctl_dma_en (ctl_dma_en),
    .ctl_svc    (ctl_svc),
    .dma_req    (dma_req),
    .svc_flag   (svc_flag)
  );

  task automatic check(input int rq, input logic ereq, input logic esvc, input string what);
    total++;
    if (dma_req !== ereq || svc_flag !== esvc) begin
      bad++;
      $display("FAIL R%0d %s: req=%b svc=%b expected req=%b svc=%b",
               rq, what, dma_req, svc_flag, ereq, esvc);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    ctl_wr     = v.wr;
    ctl_dma_en = v.en;
    ctl_svc    = v.svc;
    fifo_count = v.cnt;
    dma_ack_n  = v.ack_n;
    io_rd_n    = v.rd_n;
    term_cnt   = v.tc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst = 1'b1;
    ctl_wr = 1'b0; ctl_dma_en = 1'b0; ctl_svc = 1'b0;
    fifo_count = '0; dma_ack_n = 1'b1; io_rd_n = 1'b1; term_cnt = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(1, 1'b0, 1'b1, "state during reset"); // R1
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check(int'(TBL[i].rq), TBL[i].ereq, TBL[i].esvc, $sformatf("vector %0d", i));
    end

    // R1: reset in the middle of a transfer, then data with no write
    drive('{1'b1,1'b1,1'b0,5'd6,1'b1,1'b1,1'b0,1'b1,1'b0,4'd2});
    check(2, 1'b1, 1'b0, "armed before reset");
    @(negedge clk);
    rst = 1'b1; ctl_wr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(1, 1'b0, 1'b1, "reset mid-transfer");
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      drive('{1'b0,1'b0,1'b0,5'd6,1'b1,1'b1,1'b0,1'b0,1'b1,4'd1});
      check(1, 1'b0, 1'b1, "no request after reset without write");
    end
    // R1: writing only flag=0 leaves enable at its reset value of 0
    drive('{1'b1,1'b0,1'b0,5'd6,1'b1,1'b1,1'b0,1'b0,1'b0,4'd1});
    check(1, 1'b0, 1'b0, "enable still 0 from reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule